// File: doc/BRIEF.md
# Instruction Cache Command Controller

This block keeps the per-line bookkeeping of a small two-way set-associative instruction cache: a valid bit, a lock bit and a tag for every way of every set, plus one replacement pointer per set. The data array, the bus side and the refill transfer live elsewhere. Core fetches look the set up through a lookup port. A miss claims a replaceable way in the bookkeeping at once, and the pointer tracks which way should be replaced next.

Software drives three maintenance operations through a command port. The first drops one line, found by its address. The second clears the whole cache except the pinned lines. The third fetches a line and pins it there. The pinning operation waits on a modelled line fill, so it keeps the block busy for a parameterised number of cycles. During that time core fetches are held off. Failures are kept in sticky flags that only a write-one-to-clear removes. Clearing the whole cache is reserved for supervisor mode. Asked from user mode, it changes nothing and emits a one-cycle trap pulse.

Top module: `icache_cmd_ctrl`

## Requirements
- R1: After reset every line is invalid and unlocked, every set's replacement pointer is 0, and busy, fetch_stall, err_lock, err_busy and prog_int are 0.
- R2: A fetch_req while busy is 0 produces, on the next cycle, look_valid=1 together with:
  - look_hit and look_way;
  - the set's valid and lock masks, with bit w meaning way w;
  - the replacement pointer as it was before the access.
  
  A hit on way w moves the pointer to the other way. A miss allocates a way and then moves the pointer to the other way. The allocated way is the pointed way when it is unlocked, otherwise the other way. Allocation sets valid and the tag and leaves lock at 0. When both ways are locked, a miss allocates nothing.
- R3: cmd_op=1 (drop one line) finishes in one cycle and is accepted in either mode. It never sets an error flag. If the address hits way w, valid and lock of way w are cleared and the set's pointer becomes w. A miss changes nothing.
- R4: cmd_op=2 (clear all) with user_mode=0 finishes in one cycle. It clears valid on every unlocked line, leaves every locked line valid, and sets no error.
- R5: After clear-all, each set's pointer picks an unlocked way. It is 0 when both ways are unlocked, 1 when only way 0 is locked, and 0 when only way 1 is locked. It is unchanged when both ways are locked.
- R6: cmd_op=2 with user_mode=1 changes no line and raises prog_int for exactly the following cycle.
- R7: cmd_op=3 (fetch and pin) holds busy and fetch_stall at 1 for exactly FILL_LAT cycles, starting the cycle after issue. A fetch_req made in that window gives look_valid=0.
- R8: At the end of fetch-and-pin, the command takes the hit way if the address hits. Otherwise it takes the way that a miss would allocate. That way ends valid and locked with the new tag, and the set's pointer is aimed at the other way.
- R9: If fetch-and-pin misses and both ways of its set are locked, err_lock becomes 1 in the same cycle busy falls and not earlier. The set is left unchanged.
- R10: err_lock and err_busy hold their value until software clears them: err_clr bit 0 clears err_lock and err_clr bit 1 clears err_busy. Setting a flag wins over clearing it in the same cycle.
- R11: A command issued while busy is 1 is ignored, and it sets err_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 1 drop line, 2 clear all, 3 fetch and pin |
| cmd_line | input | TAG_W+SETS_W | Line address of the command: tag above set index |
| user_mode | input | 1 | 1 when the core runs in user mode |
| err_clr | input | 2 | Write-one-to-clear: bit 0 err_lock, bit 1 err_busy |
| fetch_req | input | 1 | Core fetch lookup request |
| fetch_line | input | TAG_W+SETS_W | Line address of the fetch |
| busy | output | 1 | Multi-cycle command in progress |
| fetch_stall | output | 1 | Core fetches are held off |
| look_valid | output | 1 | Lookup result present |
| look_hit | output | 1 | Lookup hit |
| look_way | output | 1 | Way that hit |
| look_vmask | output | 2 | Valid bits of the looked-up set |
| look_lmask | output | 2 | Lock bits of the looked-up set |
| look_lru | output | 1 | Replacement pointer of the set before the access |
| err_lock | output | 1 | Sticky fetch-and-pin failure |
| err_busy | output | 1 | Sticky command-while-busy error |
| prog_int | output | 1 | Privilege-violation pulse |

## Verification
The assertions assume the following about the inputs:
- SETS is a power of two.
- Every command arrives as a single-cycle cmd_valid strobe with a nonzero cmd_op.
- No fetch_req coincides with an accepted command that rewrites a set.

The stimulus keeps to these rules. Commands and lookups are driven on separate cycles, except inside the busy window, where the mixing is deliberate. That window is where the stall and the command-while-busy rejection are exercised. Every lookup also changes pointers and allocations, so the bench reference model replays those side effects on every probe instead of treating probes as passive reads.

// File: rtl/icache_cmd_pkg.sv
package icache_cmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_BINV  = 2'd1,
    OP_IALL  = 2'd2,
    OP_LLOCK = 2'd3
  } ic_op_e;

  typedef struct packed {
    logic [1:0] vld;
    logic [1:0] lck;
    logic       lru;
  } set_state_t;

  // pointer after a clear-all: aim at an unlocked way
  function automatic logic lru_after_iall(input logic [1:0] lck, input logic cur);
    case (lck)
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/ic_way_pick.sv
module ic_way_pick (
  input  logic [1:0] hit,
  input  logic [1:0] lck,
  input  logic       lru,
  output logic       hit_any,
  output logic       hit_way,
  output logic       can_alloc,
  output logic       alloc_way
);
  always_comb begin
    hit_any   = |hit;
    hit_way   = ~hit[0];
    can_alloc = ~&lck;
    alloc_way = lck[lru] ? ~lru : lru;
  end
endmodule

// File: rtl/ic_state_array.sv
module ic_state_array
  import icache_cmd_pkg::*;
#(
  parameter int SETS  = 32,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [IDX_W-1:0]       ra_idx,
  input  logic [IDX_W-1:0]       rb_idx,
  output set_state_t             ra_st,
  output set_state_t             rb_st,
  output logic [1:0][TAG_W-1:0]  ra_tag,
  output logic [1:0][TAG_W-1:0]  rb_tag,
  input  logic                   iall_en,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  set_state_t             wr_st,
  input  logic [1:0]             tag_we,
  input  logic [TAG_W-1:0]       tag_wd
);

  set_state_t st_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    set_state_t cur;
    always_ff @(posedge clk) begin
      if (rst) begin
        cur <= '0;
      end else if (iall_en) begin
        cur.vld <= cur.vld & cur.lck;
        cur.lru <= lru_after_iall(cur.lck, cur.lru);
      end else if (wr_en && wr_idx == IDX_W'(s)) begin
        cur <= wr_st;
      end
    end
    assign st_q[s] = cur;

    assert_iall_drops_unlocked_R4 : assert property (@(posedge clk) disable iff (rst)
      iall_en |=> ((cur.vld & ~cur.lck) == 2'b00));
    assert_iall_lru_way0_R5 : assert property (@(posedge clk) disable iff (rst)
      (iall_en && cur.lck == 2'b00) |=> (cur.lru == 1'b0));
    assert_lock_needs_valid_R8 : assert property (@(posedge clk) disable iff (rst)
      ((cur.lck & ~cur.vld) == 2'b00));
  end

  assign ra_st = st_q[ra_idx];
  assign rb_st = st_q[rb_idx];

  // one LUT-RAM per way: single write port, two asynchronous reads
  for (genvar w = 0; w < 2; w++) begin : g_tag
    logic [TAG_W-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (tag_we[w]) mem[wr_idx] <= tag_wd;
    end
    assign ra_tag[w] = mem[ra_idx];
    assign rb_tag[w] = mem[rb_idx];
  end

endmodule

// File: rtl/ic_cmd_seq.sv
module ic_cmd_seq
  import icache_cmd_pkg::*;
#(
  parameter int LA_W     = 25,
  parameter int FILL_LAT = 4,
  localparam int CNT_W   = (FILL_LAT > 1) ? $clog2(FILL_LAT) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [LA_W-1:0] cmd_line,
  input  logic            user_mode,
  input  logic [1:0]      err_clr,
  input  logic            lock_fail,
  output logic            busy,
  output logic            ll_done,
  output logic            binv_go,
  output logic            iall_go,
  output logic [LA_W-1:0] pend_line,
  output logic            err_lock,
  output logic            err_busy,
  output logic            prog_int
);

  ic_op_e           op;
  logic             take;
  logic             ll_go;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    op      = ic_op_e'(cmd_op);
    take    = cmd_valid && (op != OP_NONE);
    binv_go = take && !busy && (op == OP_BINV);
    iall_go = take && !busy && (op == OP_IALL) && !user_mode;
    ll_go   = take && !busy && (op == OP_LLOCK);
    ll_done = busy && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      pend_line <= '0;
    end else if (ll_go) begin
      busy      <= 1'b1;
      cnt       <= CNT_W'(FILL_LAT - 1);
      pend_line <= cmd_line;
    end else if (ll_done) begin
      busy      <= 1'b0;
    end else if (busy) begin
      cnt       <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_lock <= 1'b0;
      err_busy <= 1'b0;
      prog_int <= 1'b0;
    end else begin
      err_lock <= lock_fail | (err_lock & ~err_clr[0]);
      err_busy <= (take & busy) | (err_busy & ~err_clr[1]);
      prog_int <= take && !busy && (op == OP_IALL) && user_mode;
    end
  end

  assert_lock_err_sticky_R10 : assert property (@(posedge clk) disable iff (rst)
    (err_lock && !err_clr[0]) |=> err_lock);
  assert_busy_err_sticky_R10 : assert property (@(posedge clk) disable iff (rst)
    (err_busy && !err_clr[1]) |=> err_busy);
  assert_cmd_while_busy_R11 : assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op != 2'd0 && busy) |=> err_busy);
  assert_trap_source_R6 : assert property (@(posedge clk) disable iff (rst)
    prog_int |-> $past(cmd_valid && cmd_op == 2'd2 && user_mode && !busy));
  assert_busy_rise_R7 : assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && cmd_op == 2'd3));
  assert_busy_fall_R7 : assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(ll_done));
  assert_lock_err_at_end_R9 : assert property (@(posedge clk) disable iff (rst)
    $rose(err_lock) |-> $fell(busy));

endmodule

// File: rtl/icache_cmd_ctrl.sv
module icache_cmd_ctrl
  import icache_cmd_pkg::*;
#(
  parameter int SETS     = 32,
  parameter int TAG_W    = 20,
  parameter int FILL_LAT = 4,
  localparam int SETS_W  = $clog2(SETS),
  localparam int LA_W    = TAG_W + SETS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [LA_W-1:0] cmd_line,
  input  logic            user_mode,
  input  logic [1:0]      err_clr,
  input  logic            fetch_req,
  input  logic [LA_W-1:0] fetch_line,
  output logic            busy,
  output logic            fetch_stall,
  output logic            look_valid,
  output logic            look_hit,
  output logic            look_way,
  output logic [1:0]      look_vmask,
  output logic [1:0]      look_lmask,
  output logic            look_lru,
  output logic            err_lock,
  output logic            err_busy,
  output logic            prog_int
);

  logic              ll_done, binv_go, iall_go, lock_fail;
  logic [LA_W-1:0]   pend_line, c_line;
  logic [SETS_W-1:0] f_idx, c_idx;
  logic [TAG_W-1:0]  f_tag, c_tag;

  set_state_t            ra_st, rb_st, wr_st, c_wst, f_wst;
  logic [1:0][TAG_W-1:0] ra_tag, rb_tag;
  logic [1:0]            f_hit, c_hit, c_tag_we, f_tag_we, tag_we;
  logic                  c_wr_en, f_wr_en, wr_en, f_go;
  logic [SETS_W-1:0]     wr_idx;
  logic [TAG_W-1:0]      tag_wd;

  logic f_any, f_hway, f_can, f_away;
  logic c_any, c_hway, c_can, c_away;
  logic ll_way, ll_ok;

  ic_cmd_seq #(.LA_W(LA_W), .FILL_LAT(FILL_LAT)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .user_mode(user_mode), .err_clr(err_clr),
    .lock_fail(lock_fail), .busy(busy), .ll_done(ll_done),
    .binv_go(binv_go), .iall_go(iall_go), .pend_line(pend_line),
    .err_lock(err_lock), .err_busy(err_busy), .prog_int(prog_int)
  );

  assign c_line = busy ? pend_line : cmd_line;
  assign c_idx  = c_line[SETS_W-1:0];
  assign c_tag  = c_line[LA_W-1:SETS_W];
  assign f_idx  = fetch_line[SETS_W-1:0];
  assign f_tag  = fetch_line[LA_W-1:SETS_W];

  ic_state_array #(.SETS(SETS), .TAG_W(TAG_W)) u_arr (
    .clk(clk), .rst(rst), .ra_idx(f_idx), .rb_idx(c_idx),
    .ra_st(ra_st), .rb_st(rb_st), .ra_tag(ra_tag), .rb_tag(rb_tag),
    .iall_en(iall_go), .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st),
    .tag_we(tag_we), .tag_wd(tag_wd)
  );

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign f_hit[w] = ra_st.vld[w] && (ra_tag[w] == f_tag);
    assign c_hit[w] = rb_st.vld[w] && (rb_tag[w] == c_tag);
  end

  ic_way_pick u_fpick (
    .hit(f_hit), .lck(ra_st.lck), .lru(ra_st.lru),
    .hit_any(f_any), .hit_way(f_hway), .can_alloc(f_can), .alloc_way(f_away)
  );

  ic_way_pick u_cpick (
    .hit(c_hit), .lck(rb_st.lck), .lru(rb_st.lru),
    .hit_any(c_any), .hit_way(c_hway), .can_alloc(c_can), .alloc_way(c_away)
  );

  // command-side set rewrite
  always_comb begin
    c_wr_en   = 1'b0;
    c_wst     = rb_st;
    c_tag_we  = 2'b00;
    lock_fail = 1'b0;
    ll_way    = c_any ? c_hway : c_away;
    ll_ok     = c_any | c_can;
    if (binv_go) begin
      if (c_any) begin
        c_wr_en            = 1'b1;
        c_wst.vld[c_hway]  = 1'b0;
        c_wst.lck[c_hway]  = 1'b0;
        c_wst.lru          = c_hway;
      end
    end else if (ll_done) begin
      if (ll_ok) begin
        c_wr_en           = 1'b1;
        c_wst.vld[ll_way] = 1'b1;
        c_wst.lck[ll_way] = 1'b1;
        c_wst.lru         = ~ll_way;
        c_tag_we[ll_way]  = ~c_any;
      end else begin
        lock_fail = 1'b1;
      end
    end
  end

  // fetch-side pointer update and miss allocation
  assign f_go = fetch_req && !busy;

  always_comb begin
    f_wr_en  = 1'b0;
    f_wst    = ra_st;
    f_tag_we = 2'b00;
    if (f_go && !c_wr_en && !iall_go) begin
      if (f_any) begin
        f_wr_en   = 1'b1;
        f_wst.lru = ~f_hway;
      end else if (f_can) begin
        f_wr_en          = 1'b1;
        f_wst.vld[f_away] = 1'b1;
        f_wst.lru        = ~f_away;
        f_tag_we[f_away] = 1'b1;
      end
    end
  end

  always_comb begin
    wr_en  = c_wr_en | f_wr_en;
    wr_idx = c_wr_en ? c_idx    : f_idx;
    wr_st  = c_wr_en ? c_wst    : f_wst;
    tag_we = c_wr_en ? c_tag_we : f_tag_we;
    tag_wd = c_wr_en ? c_tag    : f_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      look_valid <= 1'b0;
      look_hit   <= 1'b0;
      look_way   <= 1'b0;
      look_vmask <= 2'b00;
      look_lmask <= 2'b00;
      look_lru   <= 1'b0;
    end else begin
      look_valid <= f_go;
      if (f_go) begin
        look_hit   <= f_any;
        look_way   <= f_hway;
        look_vmask <= ra_st.vld;
        look_lmask <= ra_st.lck;
        look_lru   <= ra_st.lru;
      end
    end
  end

  assign fetch_stall = busy;

  assert_no_lookup_when_busy_R7 : assert property (@(posedge clk) disable iff (rst)
    look_valid |-> $past(fetch_req && !fetch_stall));
  assert_one_write_source_R3 : assert property (@(posedge clk) disable iff (rst)
    !(binv_go && ll_done) && !(iall_go && c_wr_en));

endmodule

// File: tb/sim_icache_cmd_ctrl.sv
module sim_icache_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETS     = 32;
  localparam int TAG_W    = 20;
  localparam int FILL_LAT = 4;
  localparam int SETS_W   = $clog2(SETS);
  localparam int LA_W     = TAG_W + SETS_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [LA_W-1:0] cmd_line = '0;
  logic user_mode = 1'b0;
  logic [1:0] err_clr = 2'b00;
  logic fetch_req = 1'b0;
  logic [LA_W-1:0] fetch_line = '0;
  logic busy, fetch_stall, look_valid, look_hit, look_way, look_lru;
  logic [1:0] look_vmask, look_lmask;
  logic err_lock, err_busy, prog_int;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_cmd_ctrl #(.SETS(SETS), .TAG_W(TAG_W), .FILL_LAT(FILL_LAT)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .user_mode(user_mode), .err_clr(err_clr),
    .fetch_req(fetch_req), .fetch_line(fetch_line), .busy(busy),
    .fetch_stall(fetch_stall), .look_valid(look_valid), .look_hit(look_hit),
    .look_way(look_way), .look_vmask(look_vmask), .look_lmask(look_lmask),
    .look_lru(look_lru), .err_lock(err_lock), .err_busy(err_busy),
    .prog_int(prog_int)
  );

  int total = 0;
  int bad = 0;

  // reference model
  logic [1:0] mvl [SETS];
  logic [1:0] mlk [SETS];
  int         mlru [SETS];
  int         mtg [SETS][2];
  int         m_errl = 0;
  int         m_errb = 0;

  task automatic chk(string rq, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [LA_W-1:0] mk(int s, int t);
    return {TAG_W'(t), SETS_W'(s)};
  endfunction

  function automatic int m_hit(int s, int t);
    for (int w = 0; w < 2; w++)
      if (mvl[s][w] && mtg[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int m_victim(int s);
    if (mlk[s] == 2'b11) return -1;
    if (!mlk[s][mlru[s]]) return mlru[s];
    return 1 - mlru[s];
  endfunction

  task automatic probe(int s, int t, string rq);
    int hw, vw;
    @(negedge clk);
    fetch_req = 1'b1; fetch_line = mk(s, t);
    @(negedge clk);
    fetch_req = 1'b0;
    hw = m_hit(s, t);
    chk(rq, look_valid, 1);
    chk(rq, look_hit, (hw >= 0) ? 1 : 0);
    if (hw >= 0) chk(rq, look_way, hw);
    chk(rq, look_vmask, mvl[s]);
    chk(rq, look_lmask, mlk[s]);
    chk(rq, look_lru, mlru[s]);
    if (hw >= 0) mlru[s] = 1 - hw;
    else begin
      vw = m_victim(s);
      if (vw >= 0) begin
        mvl[s][vw] = 1'b1; mtg[s][vw] = t; mlru[s] = 1 - vw;
      end
    end
  endtask

  task automatic issue(logic [1:0] op, int s, int t, logic um);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_line = mk(s, t); user_mode = um;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0; user_mode = 1'b0;
  endtask

  task automatic binv(int s, int t, logic um);
    int hw;
    issue(2'd1, s, t, um);
    hw = m_hit(s, t);
    if (hw >= 0) begin
      mvl[s][hw] = 1'b0; mlk[s][hw] = 1'b0; mlru[s] = hw;
    end
    chk("R3", err_lock, m_errl);
    chk("R3", err_busy, m_errb);
  endtask

  task automatic iall_model();
    for (int s = 0; s < SETS; s++) begin
      mvl[s] = mvl[s] & mlk[s];
      case (mlk[s])
        2'b00: mlru[s] = 0;
        2'b01: mlru[s] = 1;
        2'b10: mlru[s] = 0;
        default: ;
      endcase
    end
  endtask

  task automatic llock(int s, int t, bit poke_fetch, bit poke_cmd);
    int n, hw, vw;
    issue(2'd3, s, t, 1'b0);
    n = 0;
    while (busy === 1'b1 && n < 64) begin
      n++;
      chk("R9", err_lock, m_errl);
      chk("R7", fetch_stall, 1);
      if (poke_fetch && n == 1) begin
        fetch_req = 1'b1; fetch_line = mk(s, t);
      end
      if (poke_fetch && n == 2) begin
        chk("R7", look_valid, 0);
        fetch_req = 1'b0;
      end
      if (poke_cmd && n == 2) begin
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_line = mk(2, 5);
      end
      if (poke_cmd && n == 3) begin
        cmd_valid = 1'b0; cmd_op = 2'd0; m_errb = 1;
      end
      @(negedge clk);
    end
    chk("R7", n, FILL_LAT);
    hw = m_hit(s, t);
    if (hw >= 0) begin
      mlk[s][hw] = 1'b1; mlru[s] = 1 - hw;
    end else begin
      vw = m_victim(s);
      if (vw < 0) m_errl = 1;
      else begin
        mvl[s][vw] = 1'b1; mlk[s][vw] = 1'b1; mtg[s][vw] = t; mlru[s] = 1 - vw;
      end
    end
    chk("R9", err_lock, m_errl);
    chk("R11", err_busy, m_errb);
  endtask

  task automatic clr(logic [1:0] b);
    @(negedge clk);
    err_clr = b;
    @(negedge clk);
    err_clr = 2'b00;
    if (b[0]) m_errl = 0;
    if (b[1]) m_errb = 0;
    chk("R10", err_lock, m_errl);
    chk("R10", err_busy, m_errb);
  endtask

  task automatic sweep(int t, string rq);
    for (int s = 0; s < SETS; s++) probe(s, t, rq);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      mvl[s] = 2'b00; mlk[s] = 2'b00; mlru[s] = 0; mtg[s][0] = 0; mtg[s][1] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", busy, 0);
    chk("R1", fetch_stall, 0);
    chk("R1", err_lock, 0);
    chk("R1", err_busy, 0);
    chk("R1", prog_int, 0);
    sweep(5, "R1");                                  // empty sets, allocates way 0
    sweep(5, "R2");                                  // hits
    for (int s = 0; s < SETS; s++) probe(s, 6 + (s % 2), "R2"); // second way
    for (int s = 0; s < SETS; s += 3) probe(s, 40, "R2");       // replacement
    // fetch-and-pin patterns
    for (int s = 0; s < SETS; s++) begin
      case (s % 4)
        0: llock(s, 5, 1'b0, 1'b0);
        1: llock(s, 9, 1'b0, 1'b0);
        2: begin llock(s, 5, 1'b0, 1'b0); llock(s, 9, 1'b0, 1'b0); end
        default: ;
      endcase
    end
    sweep(6, "R8");
    // both ways locked: error appears at completion
    llock(2, 11, 1'b0, 1'b0);
    chk("R9", err_lock, 1);
    probe(2, 11, "R9");
    probe(2, 12, "R2");                              // no allocation possible
    llock(3, 13, 1'b0, 1'b0);                        // success, flag stays
    chk("R10", err_lock, 1);
    clr(2'b01);
    // privileged clear from user mode
    issue(2'd2, 0, 0, 1'b1);
    chk("R6", prog_int, 1);
    @(negedge clk);
    chk("R6", prog_int, 0);
    sweep(5, "R6");
    // privileged clear from supervisor mode
    issue(2'd2, 0, 0, 1'b0);
    iall_model();
    chk("R4", prog_int, 0);
    chk("R4", err_lock, 0);
    chk("R4", err_busy, 0);
    for (int s = 0; s < SETS; s++) probe(s, 99, (s % 4 == 3) ? "R5" : "R4");
    // single-line drop
    binv(0, 5, 1'b1);
    probe(0, 5, "R3");
    binv(1, 77, 1'b0);
    probe(1, 9, "R3");
    binv(4, 99, 1'b0);
    probe(4, 99, "R3");
    // command while busy is ignored
    llock(3, 21, 1'b1, 1'b1);
    chk("R11", err_busy, 1);
    probe(2, 5, "R11");
    clr(2'b10);
    clr(2'b11);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule